// File: doc/BRIEF.md
# SPI Status Word Register

This block holds the status flags of an SPI controller and presents them as one read-only 32-bit status word. It takes single-cycle event strobes from the serializer, from the receive and transmit data register access logic, and from the buffer-transfer engine. It also takes the live values of four transfer counters: receive, transmit, next-receive and next-transmit. Every flag is a register that updates on the clock edge at which its event is sampled. The status word therefore shows that event one cycle after the strobe.

Error-type flags are sticky and clear on a status read. If a setting event and a clearing read land in the same cycle, the event takes priority, so no event is lost. The transmit-ready flag is tied to the enable state: it is held low while the controller is disabled and forced high by the enable command.

Top module: `spi_status_word`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `status_o` reads all zeros.
- R2: Bit 16 (enabled) is set by `enable_i` and cleared by `disable_i`. When both strobes come in one cycle, disable wins.
- R3: Bit 1 (transmit ready) is 0 whenever the block is disabled. Otherwise the priority is: the enable strobe forces it to 1, then `tx_write_i` clears it, then `tx_take_i` sets it. A write and a take in the same cycle therefore leave it at 0.
- R4: Bit 0 (receive full) is set by `rx_load_i` and cleared by `rx_read_i`. A load in the same cycle as the read wins.
- R5: Bit 3 (overrun) is set when `rx_load_i` arrives while bit 0 is already 1 and `rx_read_i` is low in that cycle. It stays set until `status_read_i`, and a new overrun in the read cycle keeps it at 1.
- R6: Bit 2 (mode fault) is set by `fault_i` and stays set until `status_read_i`. A fault in the same cycle as the read wins.
- R7: Bit 8 (slave-select release) is set by `ss_rise_i` and stays set until `status_read_i`. An event in the same cycle as the read wins.
- R8: Bit 4 (receive end) becomes 1 once `rx_cnt_i` has been sampled at 0, and stays 1 until `rx_cnt_wr_i` clears it. Bit 5 (transmit end) does the same with `tx_cnt_i` and `tx_cnt_wr_i`. A counter write wins over a zero count in the same cycle.
- R9: Bit 6 (receive drained) equals "both `rx_cnt_i` and `rx_next_cnt_i` are zero" as sampled at the previous edge. Bit 7 (transmit drained) follows the same rule for the two transmit counters.
- R10: Bit 9 (transmit idle) is 1 exactly when, after the edge, the block is enabled and bit 1 is 1, and `shifter_idle_i` was 1 at that edge.
- R11: Bits 10 to 15 and 17 to 31 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_load_i | input | 1 | Received word moved into the receive data register |
| rx_read_i | input | 1 | Bus read of the receive data register |
| tx_write_i | input | 1 | Bus write of the transmit data register |
| tx_take_i | input | 1 | Serializer took the transmit word |
| fault_i | input | 1 | Mode fault detected |
| ss_rise_i | input | 1 | Slave-select released |
| shifter_idle_i | input | 1 | Serializer has nothing left to shift |
| enable_i | input | 1 | Enable command |
| disable_i | input | 1 | Disable command |
| status_read_i | input | 1 | Bus read of the status word |
| rx_cnt_i | input | CNT_W | Receive transfer counter |
| rx_next_cnt_i | input | CNT_W | Next-receive transfer counter |
| tx_cnt_i | input | CNT_W | Transmit transfer counter |
| tx_next_cnt_i | input | CNT_W | Next-transmit transfer counter |
| rx_cnt_wr_i | input | 1 | Receive counter was written |
| tx_cnt_wr_i | input | 1 | Transmit counter was written |
| status_o | output | 32 | Status word |

## Verification
Each flag is a single register read straight onto `status_o`. A wrong internal state therefore appears on its bit one cycle after the strobe that should have set or cleared it, with nothing to delay or hide it. Sticky flags hold a wrong value until the next status read or clear strobe. The ordering cases need extra care: write against take, load against read, and event against status read. A wrong priority shows up only in the cycle after those inputs coincide, and an error in the overrun rule shows up only in that same cycle and then persists until the next status read.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

  localparam int unsigned WORD_W = 32;

  // bit positions inside the status word
  localparam int unsigned B_RX_FULL  = 0;
  localparam int unsigned B_TX_READY = 1;
  localparam int unsigned B_FAULT    = 2;
  localparam int unsigned B_OVERRUN  = 3;
  localparam int unsigned B_RX_END   = 4;
  localparam int unsigned B_TX_END   = 5;
  localparam int unsigned B_RX_DRAIN = 6;
  localparam int unsigned B_TX_DRAIN = 7;
  localparam int unsigned B_SS_REL   = 8;
  localparam int unsigned B_TX_IDLE  = 9;
  localparam int unsigned B_ENABLED  = 16;

  localparam int unsigned N_DIR = 2;  // 0: receive, 1: transmit

  typedef struct packed {
    logic enabled;
    logic tx_idle;
    logic ss_rel;
    logic tx_drain;
    logic rx_drain;
    logic tx_end;
    logic rx_end;
    logic overrun;
    logic fault;
    logic tx_ready;
    logic rx_full;
  } stat_flags_t;

  function automatic logic [WORD_W-1:0] pack_word(input stat_flags_t f);
    logic [WORD_W-1:0] w;
    w             = '0;
    w[B_RX_FULL]  = f.rx_full;
    w[B_TX_READY] = f.tx_ready;
    w[B_FAULT]    = f.fault;
    w[B_OVERRUN]  = f.overrun;
    w[B_RX_END]   = f.rx_end;
    w[B_TX_END]   = f.tx_end;
    w[B_RX_DRAIN] = f.rx_drain;
    w[B_TX_DRAIN] = f.tx_drain;
    w[B_SS_REL]   = f.ss_rel;
    w[B_TX_IDLE]  = f.tx_idle;
    w[B_ENABLED]  = f.enabled;
    return w;
  endfunction

endpackage

// File: rtl/stat_sticky.sv
// Set-dominant flag: set wins over clear in the same cycle.
module stat_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_q;
  logic q_d;
  logic upd;

  always_comb begin
    upd = set_i | clr_i;
    q_d = set_i ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_q <= 1'b0;
    else if (upd) q_q <= q_d;
  end

  assign q_o = q_q;

  // R4 R5 R6 R7: shared by every set-dominant flag
  assert_sticky_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !set_i && !clr_i) |=> q_o);
  assert_sticky_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);

endmodule

// File: rtl/stat_ctrl.sv
// Enable state, transmit-ready and transmit-idle flags.
module stat_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic disable_i,
  input  logic tx_write_i,
  input  logic tx_take_i,
  input  logic shifter_idle_i,
  output logic enabled_o,
  output logic tx_ready_o,
  output logic tx_idle_o
);

  logic en_q, en_d;
  logic rdy_q, rdy_d;
  logic idl_q, idl_d;
  logic upd;

  always_comb begin
    en_d = en_q;
    if (disable_i)     en_d = 1'b0;
    else if (enable_i) en_d = 1'b1;

    rdy_d = rdy_q;
    if (!en_d)           rdy_d = 1'b0;
    else if (enable_i)   rdy_d = 1'b1;
    else if (tx_write_i) rdy_d = 1'b0;
    else if (tx_take_i)  rdy_d = 1'b1;

    idl_d = en_d & rdy_d & shifter_idle_i;
    upd   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rdy_q <= 1'b0;
      idl_q <= 1'b0;
    end else if (upd) begin
      en_q  <= en_d;
      rdy_q <= rdy_d;
      idl_q <= idl_d;
    end
  end

  assign enabled_o  = en_q;
  assign tx_ready_o = rdy_q;
  assign tx_idle_o  = idl_q;

  assert_disable_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |=> (!enabled_o && !tx_ready_o));
  assert_enable_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && !disable_i) |=> (enabled_o && tx_ready_o));
  assert_ready_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |-> enabled_o);
  assert_write_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_write_i && !enable_i) |=> !tx_ready_o);
  assert_idle_needs_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle_o |-> (tx_ready_o && enabled_o));

endmodule

// File: rtl/stat_cnt_mon.sv
// Watches one direction's current and next transfer counters.
module stat_cnt_mon #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] next_cnt_i,
  input  logic             cnt_wr_i,
  output logic             end_o,
  output logic             drain_o
);

  localparam logic [CNT_W-1:0] ZERO = '0;

  logic end_q, end_d;
  logic drn_q, drn_d;
  logic cur_zero, nxt_zero;
  logic end_upd;

  always_comb begin
    cur_zero = (cnt_i == ZERO);
    nxt_zero = (next_cnt_i == ZERO);
    end_upd  = cnt_wr_i | cur_zero;
    end_d    = cnt_wr_i ? 1'b0 : 1'b1;
    drn_d    = cur_zero & nxt_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       end_q <= 1'b0;
    else if (end_upd) end_q <= end_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drn_q <= 1'b0;
    else        drn_q <= drn_d;
  end

  assign end_o   = end_q;
  assign drain_o = drn_q;

  assert_end_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> !end_o);
  assert_end_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (end_o && !cnt_wr_i) |=> end_o);
  assert_drain_implies_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_o && !$past(cnt_wr_i)) |-> end_o);

endmodule

// File: rtl/spi_status_word.sv
module spi_status_word
  import spi_stat_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_load_i,
  input  logic             rx_read_i,
  input  logic             tx_write_i,
  input  logic             tx_take_i,
  input  logic             fault_i,
  input  logic             ss_rise_i,
  input  logic             shifter_idle_i,
  input  logic             enable_i,
  input  logic             disable_i,
  input  logic             status_read_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [CNT_W-1:0] rx_next_cnt_i,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] tx_next_cnt_i,
  input  logic             rx_cnt_wr_i,
  input  logic             tx_cnt_wr_i,
  output logic [WORD_W-1:0] status_o
);

  localparam int unsigned N_STICKY = 4;  // rx_full, overrun, fault, ss_rel

  stat_flags_t flags;

  logic [CNT_W-1:0] cur_cnt [N_DIR];
  logic [CNT_W-1:0] nxt_cnt [N_DIR];
  logic             cnt_wr  [N_DIR];
  logic             end_f   [N_DIR];
  logic             drn_f   [N_DIR];

  logic [N_STICKY-1:0] stk_set, stk_clr, stk_q;

  always_comb begin
    cur_cnt[0] = rx_cnt_i;  nxt_cnt[0] = rx_next_cnt_i;  cnt_wr[0] = rx_cnt_wr_i;
    cur_cnt[1] = tx_cnt_i;  nxt_cnt[1] = tx_next_cnt_i;  cnt_wr[1] = tx_cnt_wr_i;
  end

  // sticky set/clear sources
  always_comb begin
    stk_set[0] = rx_load_i;
    stk_clr[0] = rx_read_i;
    stk_set[1] = rx_load_i & stk_q[0] & ~rx_read_i;
    stk_clr[1] = status_read_i;
    stk_set[2] = fault_i;
    stk_clr[2] = status_read_i;
    stk_set[3] = ss_rise_i;
    stk_clr[3] = status_read_i;
  end

  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    stat_sticky u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (stk_set[g]),
      .clr_i (stk_clr[g]),
      .q_o   (stk_q[g])
    );
  end

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    stat_cnt_mon #(.CNT_W(CNT_W)) u_mon (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_i      (cur_cnt[d]),
      .next_cnt_i (nxt_cnt[d]),
      .cnt_wr_i   (cnt_wr[d]),
      .end_o      (end_f[d]),
      .drain_o    (drn_f[d])
    );
  end

  logic en_w, rdy_w, idl_w;

  stat_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable_i       (enable_i),
    .disable_i      (disable_i),
    .tx_write_i     (tx_write_i),
    .tx_take_i      (tx_take_i),
    .shifter_idle_i (shifter_idle_i),
    .enabled_o      (en_w),
    .tx_ready_o     (rdy_w),
    .tx_idle_o      (idl_w)
  );

  always_comb begin
    flags.rx_full  = stk_q[0];
    flags.overrun  = stk_q[1];
    flags.fault    = stk_q[2];
    flags.ss_rel   = stk_q[3];
    flags.rx_end   = end_f[0];
    flags.tx_end   = end_f[1];
    flags.rx_drain = drn_f[0];
    flags.tx_drain = drn_f[1];
    flags.tx_ready = rdy_w;
    flags.tx_idle  = idl_w;
    flags.enabled  = en_w;
    status_o       = pack_word(flags);
  end

  assert_overrun_on_double_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load_i && status_o[B_RX_FULL] && !rx_read_i) |=> status_o[B_OVERRUN]);
  assert_load_sets_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load_i |=> status_o[B_RX_FULL]);
  assert_fault_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[B_FAULT] && !status_read_i) |=> status_o[B_FAULT]);
  assert_ssrel_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[B_SS_REL] && !status_read_i) |=> status_o[B_SS_REL]);

endmodule

// File: tb/tb_spi_status_word.sv
module tb_spi_status_word;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int RAND_CYCLES = 6000;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_load, rx_read, tx_write, tx_take, fault, ss_rise, sh_idle;
  logic en_cmd, dis_cmd, st_read, rxc_wr, txc_wr;
  logic [CW-1:0] rxc, rxn, txc, txn;
  logic [31:0] status;

  int checks = 0;
  int errors = 0;

  // expected state
  logic e_en, e_rdy, e_idl, e_full, e_ovr, e_flt, e_ss, e_rxe, e_txe, e_rxd, e_txd;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_status_word #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .rx_load_i(rx_load), .rx_read_i(rx_read), .tx_write_i(tx_write), .tx_take_i(tx_take),
    .fault_i(fault), .ss_rise_i(ss_rise), .shifter_idle_i(sh_idle),
    .enable_i(en_cmd), .disable_i(dis_cmd), .status_read_i(st_read),
    .rx_cnt_i(rxc), .rx_next_cnt_i(rxn), .tx_cnt_i(txc), .tx_next_cnt_i(txn),
    .rx_cnt_wr_i(rxc_wr), .tx_cnt_wr_i(txc_wr), .status_o(status)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    rx_load = 0; rx_read = 0; tx_write = 0; tx_take = 0; fault = 0; ss_rise = 0;
    en_cmd = 0; dis_cmd = 0; st_read = 0; rxc_wr = 0; txc_wr = 0;
  endtask

  task automatic clear_model();
    {e_en, e_rdy, e_idl, e_full, e_ovr, e_flt, e_ss, e_rxe, e_txe, e_rxd, e_txd} = '0;
  endtask

  // compute expected next state from the requirements, clock, then compare
  task automatic step_check();
    logic n_en, n_rdy;
    n_en  = dis_cmd ? 1'b0 : (en_cmd ? 1'b1 : e_en);
    n_rdy = !n_en ? 1'b0 : en_cmd ? 1'b1 : tx_write ? 1'b0 : tx_take ? 1'b1 : e_rdy;
    e_ovr  = (rx_load && e_full && !rx_read) || (e_ovr && !st_read);
    e_full = rx_load || (e_full && !rx_read);
    e_flt  = fault || (e_flt && !st_read);
    e_ss   = ss_rise || (e_ss && !st_read);
    e_rxe  = rxc_wr ? 1'b0 : (e_rxe || (rxc == 0));
    e_txe  = txc_wr ? 1'b0 : (e_txe || (txc == 0));
    e_rxd  = (rxc == 0) && (rxn == 0);
    e_txd  = (txc == 0) && (txn == 0);
    e_idl  = n_en && n_rdy && sh_idle;
    e_en   = n_en;
    e_rdy  = n_rdy;
    @(posedge clk); #1;
    chk("R4 receive full",     32'(status[0]),  32'(e_full));
    chk("R3 transmit ready",   32'(status[1]),  32'(e_rdy));
    chk("R6 mode fault",       32'(status[2]),  32'(e_flt));
    chk("R5 overrun",          32'(status[3]),  32'(e_ovr));
    chk("R8 receive end",      32'(status[4]),  32'(e_rxe));
    chk("R8 transmit end",     32'(status[5]),  32'(e_txe));
    chk("R9 receive drained",  32'(status[6]),  32'(e_rxd));
    chk("R9 transmit drained", 32'(status[7]),  32'(e_txd));
    chk("R7 ss release",       32'(status[8]),  32'(e_ss));
    chk("R10 transmit idle",   32'(status[9]),  32'(e_idl));
    chk("R2 enabled",          32'(status[16]), 32'(e_en));
    chk("R11 unused bits zero", status & 32'hFFFE_FC00, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle_inputs();
    sh_idle = 1; rxc = 4'd5; rxn = 4'd5; txc = 4'd5; txn = 4'd5;
    rst_n = 0;
    clear_model();
    #(CLK_PERIOD * 3 + 1);
    chk("R1 word in reset", status, 32'h0);
    @(negedge clk); rst_n = 1;
    step_check();
    chk("R1 word after reset", status, 32'h0);

    // directed: enable and disable together (R2), disable wins
    en_cmd = 1; dis_cmd = 1; step_check(); idle_inputs();
    chk("R2 disable wins", 32'(status[16]), 32'h0);
    en_cmd = 1; step_check(); idle_inputs();
    // write and take together (R3): write wins
    tx_write = 1; tx_take = 1; step_check(); idle_inputs();
    chk("R3 write beats take", 32'(status[1]), 32'h0);
    tx_take = 1; step_check(); idle_inputs();
    // double load without read (R5), then load with read (no overrun)
    rx_load = 1; step_check(); step_check(); idle_inputs();
    chk("R5 overrun set", 32'(status[3]), 32'h1);
    st_read = 1; fault = 1; step_check(); idle_inputs();
    chk("R5 overrun cleared by status read", 32'(status[3]), 32'h0);
    chk("R6 fault wins over read", 32'(status[2]), 32'h1);
    rx_load = 1; rx_read = 1; step_check(); idle_inputs();
    chk("R4 load wins over read", 32'(status[0]), 32'h1);
    chk("R5 no overrun when read same cycle", 32'(status[3]), 32'h0);

    // exhaustive counter-pair sweep (R8 R9)
    for (int a = 0; a < (1 << CW); a++) begin
      for (int b = 0; b < (1 << CW); b++) begin
        rxc = CW'(a); rxn = CW'(b); txc = CW'(b); txn = CW'(a);
        rxc_wr = (b == 3); txc_wr = (a == 7);
        step_check();
      end
    end
    idle_inputs();

    // random mixed traffic
    for (int i = 0; i < RAND_CYCLES; i++) begin
      int unsigned v;
      v = $urandom;
      rx_load  = (v[2:0] == 0);
      rx_read  = (v[5:3] == 0);
      tx_write = (v[7:6] == 0);
      tx_take  = (v[9:8] == 0);
      fault    = (v[13:10] == 0);
      ss_rise  = (v[17:14] == 0);
      st_read  = (v[20:18] == 0);
      en_cmd   = (v[24:21] == 0);
      dis_cmd  = (v[29:25] == 0);
      sh_idle  = v[30];
      v = $urandom;
      rxc_wr = (v[3:0] == 0);
      txc_wr = (v[7:4] == 0);
      rxc = v[8]  ? '0 : CW'(v[15:12]);
      rxn = v[9]  ? '0 : CW'(v[19:16]);
      txc = v[10] ? '0 : CW'(v[23:20]);
      txn = v[11] ? '0 : CW'(v[27:24]);
      step_check();
    end
    idle_inputs();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule